// File: doc/BRIEF.md
# General-Purpose Pin Controller with Function Select

This block is a register-mapped controller for a bank of general-purpose pins (22 by default). Software reaches it through a simple word-wide read/write port. It drives an output-data vector and an output-enable vector toward the pads. It samples the pad inputs through a synchronizer. Each pin has a two-bit function index that an external routing fabric uses to hand the pin to a peripheral. Index 0 keeps the pin as a plain GPIO.

Output bits can be rewritten whole, or changed atomically through separate set and clear words. This lets several software agents touch different pins without a read-modify-write. Every pin also feeds an interrupt capture stage. A pin can raise its pending flag on either edge or, when selected, whenever it is high. Pending flags are sticky and cleared by writing ones. A per-pin enable forms a masked identity view, and any bit set in that view drives a single combined interrupt line.

Reads are combinational from the registered state. Writes take effect at the clock edge that samples the write strobe.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: The word address (byte address bits above bit 1) selects the register. 0x00 is output set, 0x04 output clear, 0x08 output data, 0x0C input, 0x10 output enable, 0x14 pending, 0x18 interrupt enable, 0x1C masked identity, 0x20 function bit 0, 0x24 function bit 1, 0x28 spare storage and 0x2C trigger mode. The set and clear words read as zero. Any other address reads zero and ignores writes.
- R2: Only bits 0 to 21 hold state. Bits 22 to 31 of every read are zero, and writes to them are ignored.
- R3: Writing the set word turns on each output bit written as 1. Writing the clear word turns off each output bit written as 1. Bits written as 0 keep their value.
- R4: The output data word is read and written directly and drives the pin output vector. The output-enable word drives the pin enable vector, where 1 means the pin drives.
- R5: The input word returns the pin levels after a two-flop synchronizer. A pin change is visible on the second clock edge after it is applied. Writes to the input word and to the identity word are ignored.
- R6: The function output for pin p is the two bits {function bit 1 word bit p, function bit 0 word bit p}, placed at bits 2p+1:2p. A value of 0 selects GPIO.
- R7: With its trigger-mode bit at 0, a pin sets its pending bit on either edge of the synchronized input. A pending bit stays set until a 1 is written to it, and writing 0 leaves it unchanged.
- R8: With its trigger-mode bit at 1, a pin sets its pending bit whenever its synchronized input is high. A cleared bit therefore sets again while the pin stays high, and stays clear once the pin is low.
- R9: When a hardware set and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: The identity word reads pending AND enable. The interrupt output is high exactly when that word is nonzero.
- R11: After reset, every register, the pin outputs, the function outputs and the interrupt output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 7 | Byte address of the accessed word |
| busWe | input | 1 | Write strobe, one word per cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pinIn | input | 22 | Raw pad input levels |
| pinOut | output | 22 | Output data toward the pads |
| pinOe | output | 22 | Output enable toward the pads |
| pinFunc | output | 44 | Two-bit function index per pin |
| irqOut | output | 1 | Combined interrupt |

## Verification
A wrong output or enable bit shows on pinOut or pinOe in the cycle after the offending write, and is also visible on a readback. A wrong synchronizer or edge-detect state shows up as a pending bit that appears too early, too late or never. This is observed two to three edges after a pin change, both through the pending word and, with the enable set, on irqOut. A wrong priority between the set and the clear shows only when a clear lands on the exact edge that captures a pin change. The bench aligns one write to that edge.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  // Word indices (byte address >> 2)
  localparam int unsigned WORD_OUT_SET = 0;
  localparam int unsigned WORD_OUT_CLR = 1;
  localparam int unsigned WORD_OUT     = 2;
  localparam int unsigned WORD_IN      = 3;
  localparam int unsigned WORD_OE      = 4;
  localparam int unsigned WORD_PEND    = 5;
  localparam int unsigned WORD_ENA     = 6;
  localparam int unsigned WORD_IDENT   = 7;
  localparam int unsigned WORD_FUNC0   = 8;
  localparam int unsigned WORD_FUNC1   = 9;
  localparam int unsigned WORD_SPARE   = 10;
  localparam int unsigned WORD_MODE    = 11;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_OUT, SEL_IN, SEL_OE, SEL_PEND, SEL_ENA,
    SEL_IDENT, SEL_FUNC0, SEL_FUNC1, SEL_SPARE, SEL_MODE
  } readSel_e;

  typedef struct packed {
    logic outSet;
    logic outClr;
    logic outWr;
    logic oeWr;
    logic pendClr;
    logic enaWr;
    logic func0Wr;
    logic func1Wr;
    logic spareWr;
    logic modeWr;
  } wrStrobe_t;

endpackage

// File: rtl/gpio_mux_decode.sv
module gpio_mux_decode
  import gpio_mux_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output wrStrobe_t         stb,
  output readSel_e          rdSel
);

  int unsigned wordNum;
  logic [1:0] unusedLow;
  assign unusedLow = busAddr[1:0];

  always_comb begin
    wordNum = 32'(busAddr[ADDR_W-1:2]);
    stb     = '0;
    rdSel   = SEL_NONE;
    case (wordNum)
      WORD_OUT_SET: stb.outSet = busWe;
      WORD_OUT_CLR: stb.outClr = busWe;
      WORD_OUT:     begin stb.outWr   = busWe; rdSel = SEL_OUT;   end
      WORD_IN:      rdSel = SEL_IN;
      WORD_OE:      begin stb.oeWr    = busWe; rdSel = SEL_OE;    end
      WORD_PEND:    begin stb.pendClr = busWe; rdSel = SEL_PEND;  end
      WORD_ENA:     begin stb.enaWr   = busWe; rdSel = SEL_ENA;   end
      WORD_IDENT:   rdSel = SEL_IDENT;
      WORD_FUNC0:   begin stb.func0Wr = busWe; rdSel = SEL_FUNC0; end
      WORD_FUNC1:   begin stb.func1Wr = busWe; rdSel = SEL_FUNC1; end
      WORD_SPARE:   begin stb.spareWr = busWe; rdSel = SEL_SPARE; end
      WORD_MODE:    begin stb.modeWr  = busWe; rdSel = SEL_MODE;  end
      default: ;
    endcase
  end

  // R1: at most one register is written per cycle
  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

endmodule

// File: rtl/gpio_mux_sync.sv
module gpio_mux_sync #(
  parameter int NUM_PINS = 22
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] syncLvl,
  output logic [NUM_PINS-1:0] edgeHit
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic meta;
    logic stable;
    logic last;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta   <= 1'b0;
        stable <= 1'b0;
        last   <= 1'b0;
      end else begin
        meta   <= pinIn[p];
        stable <= meta;
        last   <= stable;
      end
    end
    assign syncLvl[p] = stable;
    assign edgeHit[p] = stable ^ last;
  end

endmodule

// File: rtl/gpio_mux_datapath.sv
module gpio_mux_datapath
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int DATA_W   = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wrStrobe_t             stb,
  input  readSel_e              rdSel,
  input  logic [NUM_PINS-1:0]   wrData,
  input  logic [NUM_PINS-1:0]   syncLvl,
  input  logic [NUM_PINS-1:0]   edgeHit,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_PINS-1:0]   outVal,
  output logic [NUM_PINS-1:0]   oeVal,
  output logic [2*NUM_PINS-1:0] funcSel,
  output logic                  irqLine
);

  logic [NUM_PINS-1:0] outReg, oeReg, pendReg, enaReg;
  logic [NUM_PINS-1:0] func0Reg, func1Reg, spareReg, modeReg;
  logic [NUM_PINS-1:0] hwSet, clrMask, identVec, readVec;

  assign hwSet    = (modeReg & syncLvl) | (~modeReg & edgeHit);
  assign clrMask  = stb.pendClr ? wrData : '0;
  assign identVec = pendReg & enaReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg   <= '0;
      oeReg    <= '0;
      pendReg  <= '0;
      enaReg   <= '0;
      func0Reg <= '0;
      func1Reg <= '0;
      spareReg <= '0;
      modeReg  <= '0;
    end else begin
      if (stb.outWr)       outReg <= wrData;
      else if (stb.outSet) outReg <= outReg | wrData;
      else if (stb.outClr) outReg <= outReg & ~wrData;
      if (stb.oeWr)    oeReg    <= wrData;
      if (stb.enaWr)   enaReg   <= wrData;
      if (stb.func0Wr) func0Reg <= wrData;
      if (stb.func1Wr) func1Reg <= wrData;
      if (stb.spareWr) spareReg <= wrData;
      if (stb.modeWr)  modeReg  <= wrData;
      pendReg <= (pendReg & ~clrMask) | hwSet;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_OUT:   readVec = outReg;
      SEL_IN:    readVec = syncLvl;
      SEL_OE:    readVec = oeReg;
      SEL_PEND:  readVec = pendReg;
      SEL_ENA:   readVec = enaReg;
      SEL_IDENT: readVec = identVec;
      SEL_FUNC0: readVec = func0Reg;
      SEL_FUNC1: readVec = func1Reg;
      SEL_SPARE: readVec = spareReg;
      SEL_MODE:  readVec = modeReg;
      default:   readVec = '0;
    endcase
  end

  assign rdData  = DATA_W'(readVec);
  assign outVal  = outReg;
  assign oeVal   = oeReg;
  assign irqLine = |identVec;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_func
    assign funcSel[2*p +: 2] = {func1Reg[p], func0Reg[p]};
  end

  assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.outSet |=> ((outReg & $past(wrData)) == $past(wrData)));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.outClr |=> ((outReg & $past(wrData)) == '0));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.pendClr |=> (($past(pendReg) & ~pendReg) == '0));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.pendClr |=> (($past(hwSet) & ~pendReg) == '0));

endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWe,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [2*NUM_PINS-1:0] pinFunc,
  output logic                  irqOut
);

  wrStrobe_t           stb;
  readSel_e            rdSel;
  logic [NUM_PINS-1:0] syncLvl, edgeHit;
  logic                unusedBits;

  assign unusedBits = ^busWdata[DATA_W-1:NUM_PINS];

  gpio_mux_decode #(.ADDR_W(ADDR_W)) uDecode (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .stb(stb), .rdSel(rdSel)
  );

  gpio_mux_sync #(.NUM_PINS(NUM_PINS)) uSync (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .syncLvl(syncLvl), .edgeHit(edgeHit)
  );

  gpio_mux_datapath #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel),
    .wrData(busWdata[NUM_PINS-1:0]), .syncLvl(syncLvl), .edgeHit(edgeHit),
    .rdData(busRdata), .outVal(pinOut), .oeVal(pinOe),
    .funcSel(pinFunc), .irqLine(irqOut)
  );

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:NUM_PINS] == '0);

endmodule

// File: tb/gpio_mux_ctrl_test.sv
module gpio_mux_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [21:0] pinIn = '0;
  logic [21:0] pinOut, pinOe;
  logic [43:0] pinFunc;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_mux_ctrl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .pinFunc(pinFunc), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #1 d = busRdata;
  endtask

  task automatic settleAndClear();
    repeat (4) @(negedge clk);
    wr(7'h14, 32'h003F_FFFF);
  endtask

  task automatic testReset();
    logic [31:0] d;
    rd(7'h08, d); check("R11 out", d, 0);
    rd(7'h10, d); check("R11 oe", d, 0);
    rd(7'h14, d); check("R11 pending", d, 0);
    rd(7'h2C, d); check("R11 mode", d, 0);
    check("R11 pinFunc", pinFunc, 0);
    check("R11 irq", irqOut, 0);
  endtask

  task automatic testSetClr();
    logic [31:0] d;
    wr(7'h00, 32'h0000_00F0);
    rd(7'h08, d); check("R3 set", d, 32'hF0);
    wr(7'h04, 32'h0000_0030);
    rd(7'h08, d); check("R3 clr", d, 32'hC0);
    wr(7'h00, 32'h0);
    rd(7'h08, d); check("R3 set zero no effect", d, 32'hC0);
    wr(7'h04, 32'h0);
    check("R3 clr zero no effect pin", pinOut, 22'hC0);
    rd(7'h00, d); check("R1 set word reads zero", d, 0);
  endtask

  task automatic testOutOe();
    logic [31:0] d;
    wr(7'h08, 32'h0015_5555);
    rd(7'h08, d); check("R4 out read", d, 32'h15_5555);
    check("R4 pinOut", pinOut, 22'h15_5555);
    wr(7'h10, 32'h002A_AAAA);
    check("R4 pinOe", pinOe, 22'h2A_AAAA);
    wr(7'h08, 32'h0);
    wr(7'h10, 32'h0);
  endtask

  task automatic testUpper();
    logic [31:0] d;
    wr(7'h08, 32'hFFFF_FFFF);
    rd(7'h08, d); check("R2 upper bits zero", d, 32'h003F_FFFF);
    wr(7'h08, 32'h0);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    wr(7'h10, 32'h5);
    wr(7'h30, 32'hFFFF_FFFF);
    wr(7'h60, 32'hFFFF_FFFF);
    rd(7'h30, d); check("R1 unmapped reads zero", d, 0);
    rd(7'h10, d); check("R1 unmapped write ignored", d, 32'h5);
    check("R1 pinOut untouched", pinOut, 0);
    wr(7'h28, 32'h0000_0123);
    rd(7'h28, d); check("R1 spare storage", d, 32'h123);
    wr(7'h10, 32'h0);
  endtask

  task automatic testInput();
    logic [31:0] d;
    @(negedge clk);
    busAddr = 7'h0C;
    pinIn = 22'h0002AB;
    @(negedge clk); #1 check("R5 in after one edge", busRdata, 0);
    @(negedge clk); #1 check("R5 in after two edges", busRdata, 32'h2AB);
    wr(7'h0C, 32'h0);
    rd(7'h0C, d); check("R5 in write ignored", d, 32'h2AB);
    wr(7'h1C, 32'hFFFF_FFFF);
    rd(7'h1C, d); check("R5 ident write ignored", d, 0);
    @(negedge clk); pinIn = '0;
    settleAndClear();
  endtask

  task automatic testFunc();
    wr(7'h20, 32'h0000_0008);
    wr(7'h24, 32'h0000_0028);
    check("R6 pin3 func 3", pinFunc[7:6], 2'd3);
    check("R6 pin5 func 2", pinFunc[11:10], 2'd2);
    check("R6 other pins gpio", pinFunc & ~44'h0000_0000_CC0, 0);
    wr(7'h20, 32'h0);
    wr(7'h24, 32'h0);
  endtask

  task automatic testEdge();
    logic [31:0] d;
    @(negedge clk); pinIn[4] = 1'b1;
    repeat (4) @(negedge clk);
    rd(7'h14, d); check("R7 rise pending", d, 32'h10);
    wr(7'h14, 32'h0);
    rd(7'h14, d); check("R7 write zero no effect", d, 32'h10);
    wr(7'h14, 32'h10);
    rd(7'h14, d); check("R7 write one clears", d, 0);
    @(negedge clk); pinIn[4] = 1'b0;
    repeat (4) @(negedge clk);
    rd(7'h14, d); check("R7 fall pending", d, 32'h10);
    wr(7'h14, 32'h10);
  endtask

  task automatic testIdent();
    logic [31:0] d;
    @(negedge clk); pinIn[7] = 1'b1;
    repeat (4) @(negedge clk);
    rd(7'h1C, d); check("R10 ident masked", d, 0);
    check("R10 irq masked", irqOut, 0);
    wr(7'h18, 32'h80);
    rd(7'h1C, d); check("R10 ident enabled", d, 32'h80);
    check("R10 irq high", irqOut, 1);
    wr(7'h14, 32'h80);
    check("R10 irq low after clear", irqOut, 0);
    @(negedge clk); pinIn[7] = 1'b0;
    settleAndClear();
    wr(7'h18, 32'h0);
  endtask

  task automatic testLevel();
    logic [31:0] d;
    wr(7'h2C, 32'h200);
    @(negedge clk); pinIn[9] = 1'b1;
    repeat (4) @(negedge clk);
    rd(7'h14, d); check("R8 level pending", d, 32'h200);
    wr(7'h14, 32'h200);
    rd(7'h14, d); check("R8 level reasserts", d, 32'h200);
    @(negedge clk); pinIn[9] = 1'b0;
    repeat (4) @(negedge clk);
    rd(7'h14, d); check("R8 stays pending after fall", d, 32'h200);
    wr(7'h14, 32'h200);
    rd(7'h14, d); check("R8 clear after fall", d, 0);
    wr(7'h2C, 32'h0);
  endtask

  task automatic testSetWins();
    logic [31:0] d;
    @(negedge clk); pinIn[12] = 1'b1;
    @(negedge clk);
    wr(7'h14, 32'h1000);  // strobe lands on the capturing edge
    rd(7'h14, d); check("R9 set wins over clear", d, 32'h1000);
    @(negedge clk); pinIn[12] = 1'b0;
    settleAndClear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSetClr();
    testOutOe();
    testUpper();
    testUnmapped();
    testInput();
    testFunc();
    testEdge();
    testIdent();
    testLevel();
    testSetWins();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule